// File: doc/BRIEF.md
# Identifier CRC-8 Checker

This block validates a nine-byte identity record that arrives one byte at a time on a valid/data stream. The first byte of a record is flagged by a start pulse and carries the stored checksum. The eight bytes that follow form a 64-bit unique identifier. The block runs a CRC-8 over the identifier bytes as they arrive. After the last one it compares the result with the stored checksum.

When the record is complete, the block raises a one-cycle completion pulse. It also presents the computed CRC and a match flag. It publishes the identifier on its output only when the checksum matches. A record that fails the check leaves the previously accepted identifier in place, so downstream logic never sees an identifier that was not verified. A new start pulse opens a fresh record at any point, and it discards whatever partial record was in progress.

Top module: `uid_crc8_check`

## Requirements
- R1: While and after reset, `done` is 0, `id_ok` is 0, `crc_value` is 0x00 and `uid_out` is 0.
- R2: A byte accepted with `in_valid` and `in_start` both high is taken as the stored checksum. The byte counter and the CRC register restart from the initial value 0xFF.
- R3: The CRC is computed over the eight identifier bytes in arrival order with polynomial 0x07 and initial value 0xFF. Each byte is XORed into the register, then eight left shifts are applied, and 0x07 is XORed in whenever the bit shifted out is 1. No reflection and no final XOR are applied. The result appears on `crc_value`.
- R4: `id_ok` is 1 exactly when the computed CRC equals the stored checksum byte of the same record. It is updated together with `done`.
- R5: `done` is a one-cycle pulse, high in the cycle after the clock edge that accepts the eighth identifier byte.
- R6: The identifier is assembled little-endian. The first identifier byte lands in `uid_out[7:0]` and the eighth in `uid_out[63:56]`. `uid_out` is updated at the `done` edge only on a match.
- R7: On a mismatch, `id_ok` is 0 and `uid_out` keeps the last accepted identifier.
- R8: Cycles with `in_valid` low are ignored, so idle gaps between bytes do not change the result.
- R9: Bytes without an open record are ignored. This covers bytes before any start pulse and bytes after the eighth identifier byte. Such bytes raise no `done` and change no output.
- R10: A start pulse in the middle of a record abandons it. Only the new record produces a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_start | input | 1 | Marks the checksum byte that opens a record (qualified by in_valid) |
| in_valid | input | 1 | Byte on in_data is valid this cycle |
| in_data | input | 8 | Stream byte |
| done | output | 1 | One-cycle pulse when a record completes |
| id_ok | output | 1 | Computed CRC matched the stored checksum |
| crc_value | output | 8 | CRC computed over the last completed record |
| uid_out | output | 64 | Last identifier that passed the check |

## Verification
The bench sweeps every value of the first identifier byte and a series of pseudo-random identifiers, and predicts each CRC with a bit-serial model. A design with a wrong polynomial, a wrong seed, a final inversion or a reversed byte order would fail these checks on `crc_value` and `uid_out`. Each single-bit corruption of the stored checksum is sent to catch a comparator that tests too few bits. After each corruption the bench checks that the earlier identifier survives. Idle gaps, bytes outside a record and a restart halfway through a record are also exercised. A counter that treats them as data would produce a spurious or misplaced `done` pulse.

// File: rtl/uidchk_pkg.sv
package uidchk_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef struct packed {
        logic              start;
        logic              valid;
        logic [BYTE_W-1:0] data;
    } beat_t;

    // One byte through the CRC-8: XOR in, then eight shift steps.
    function automatic logic [BYTE_W-1:0] crc8_byte(
        input logic [BYTE_W-1:0] crc_in,
        input logic [BYTE_W-1:0] din,
        input logic [BYTE_W-1:0] poly
    );
        logic [BYTE_W-1:0] r;
        r = crc_in ^ din;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[BYTE_W-1])
                r = {r[BYTE_W-2:0], 1'b0} ^ poly;
            else
                r = {r[BYTE_W-2:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/uidchk_ctrl.sv
module uidchk_ctrl
    import uidchk_pkg::*;
#(
    parameter int unsigned ID_BYTES = 8,
    localparam int unsigned CW = $clog2(ID_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  beat_t         beat,
    output logic          take_chk,
    output logic          take_id,
    output logic          last_id,
    output logic          open_q,
    output logic [CW-1:0] cnt_q
);

    always_comb begin
        take_chk = beat.valid && beat.start;
        take_id  = beat.valid && !beat.start && open_q;
        last_id  = take_id && (cnt_q == CW'(ID_BYTES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (take_chk) begin
            open_q <= 1'b1;
            cnt_q  <= '0;
        end else if (take_id) begin
            if (last_id) begin
                open_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(ID_BYTES));

    assert_closed_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !open_q |-> cnt_q == '0);

    assert_start_opens_R10: assert property (@(posedge clk) disable iff (rst)
        take_chk |=> (open_q && cnt_q == '0));

endmodule

// File: rtl/uidchk_crc.sv
module uidchk_crc
    import uidchk_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POLY = 8'h07,
    parameter logic [BYTE_W-1:0] INIT = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_chk,
    input  logic              take_id,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] crc_next,
    output logic [BYTE_W-1:0] chk_q
);

    logic [BYTE_W-1:0] crc_q;

    always_comb crc_next = crc8_byte(crc_q, din, POLY);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= INIT;
            chk_q <= '0;
        end else if (take_chk) begin
            crc_q <= INIT;
            chk_q <= din;
        end else if (take_id) begin
            crc_q <= crc_next;
        end
    end

    assert_seed_on_start_R2: assert property (@(posedge clk) disable iff (rst)
        take_chk |=> crc_q == INIT);

    assert_crc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(take_chk || take_id) |=> $stable(crc_q));

endmodule

// File: rtl/uidchk_asm.sv
module uidchk_asm
    import uidchk_pkg::*;
#(
    parameter int unsigned ID_BYTES = 8,
    localparam int unsigned UW = ID_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_chk,
    input  logic              take_id,
    input  logic [BYTE_W-1:0] din,
    output logic [UW-1:0]     asm_next
);

    logic [UW-1:0] acc_q;

    // New byte enters at the top and earlier bytes shift down, so after
    // the last byte the first identifier byte occupies the low lane.
    generate
        if (ID_BYTES > 1) begin : g_multi
            always_comb asm_next = {din, acc_q[UW-1:BYTE_W]};
        end else begin : g_single
            always_comb asm_next = din;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || take_chk)
            acc_q <= '0;
        else if (take_id)
            acc_q <= asm_next;
    end

    assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(take_chk || take_id) |=> $stable(acc_q));

endmodule

// File: rtl/uid_crc8_check.sv
module uid_crc8_check
    import uidchk_pkg::*;
#(
    parameter int unsigned ID_BYTES = 8,
    parameter logic [7:0] POLY = 8'h07,
    parameter logic [7:0] INIT = 8'hFF,
    localparam int unsigned UW = ID_BYTES * BYTE_W,
    localparam int unsigned CW = $clog2(ID_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_start,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          done,
    output logic          id_ok,
    output logic [7:0]    crc_value,
    output logic [UW-1:0] uid_out
);

    beat_t             beat;
    logic              take_chk, take_id, last_id, open_q;
    logic [CW-1:0]     cnt_q;
    logic [BYTE_W-1:0] crc_next, chk_q;
    logic [UW-1:0]     asm_next;
    logic              match;

    always_comb begin
        beat.start = in_start;
        beat.valid = in_valid;
        beat.data  = in_data;
        match      = (crc_next == chk_q);
    end

    uidchk_ctrl #(.ID_BYTES(ID_BYTES)) u_ctrl (
        .clk(clk), .rst(rst), .beat(beat),
        .take_chk(take_chk), .take_id(take_id), .last_id(last_id),
        .open_q(open_q), .cnt_q(cnt_q)
    );

    uidchk_crc #(.POLY(POLY), .INIT(INIT)) u_crc (
        .clk(clk), .rst(rst), .take_chk(take_chk), .take_id(take_id),
        .din(in_data), .crc_next(crc_next), .chk_q(chk_q)
    );

    uidchk_asm #(.ID_BYTES(ID_BYTES)) u_asm (
        .clk(clk), .rst(rst), .take_chk(take_chk), .take_id(take_id),
        .din(in_data), .asm_next(asm_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            id_ok     <= 1'b0;
            crc_value <= '0;
            uid_out   <= '0;
        end else begin
            done <= last_id;
            if (last_id) begin
                crc_value <= crc_next;
                id_ok     <= match;
                if (match)
                    uid_out <= asm_next;
            end
        end
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_byte_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid));

    assert_uid_guarded_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(uid_out) |-> (done && id_ok));

    assert_ok_changes_on_done_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(id_ok) |-> done);

endmodule

// File: tb/uid_crc8_check_test.sv
`timescale 1ns/1ps
module uid_crc8_check_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_start, in_valid;
    logic [7:0]  in_data;
    logic        done, id_ok;
    logic [7:0]  crc_value;
    logic [63:0] uid_out;

    int npass = 0;
    int nfail = 0;
    int cyc   = 0;
    logic [63:0] last_uid = 64'd0;

    always #2.5 clk = ~clk;

    uid_crc8_check uut (
        .clk(clk), .rst(rst), .in_start(in_start), .in_valid(in_valid),
        .in_data(in_data), .done(done), .id_ok(id_ok),
        .crc_value(crc_value), .uid_out(uid_out)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            $display("%0d/%0d checks passed", npass, npass + nfail);
            $finish;
        end
    end

    task automatic check(input logic cond, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        if (cond) npass++;
        else begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bit-serial model: feed identifier bits MSB first through the register.
    function automatic logic [7:0] model_crc(input logic [63:0] id);
        logic [7:0] c;
        logic fb;
        c = 8'hFF;
        for (int k = 0; k < 8; k++)
            for (int b = 7; b >= 0; b--) begin
                fb = c[7] ^ id[8*k + b];
                c  = {c[6:0], 1'b0};
                if (fb) c = c ^ 8'h07;
            end
        return c;
    endfunction

    task automatic drive(input logic s, input logic [7:0] d);
        @(negedge clk);
        in_start = s; in_valid = 1'b1; in_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_start = 1'b0; in_valid = 1'b0; in_data = 8'hA5;
        end
    endtask

    // Send a record; idle cycles between bytes; returns at the negedge
    // right after the edge that took the last byte.
    task automatic send_rec(input logic [7:0] chk, input logic [63:0] id, input int gap);
        drive(1'b1, chk);
        for (int k = 0; k < 8; k++) begin
            if (gap > 0) idle(gap);
            drive(1'b0, id[8*k +: 8]);
        end
        idle(1);
    endtask

    task automatic expect_done(input logic ok, input logic [63:0] id,
                               input logic [7:0] crc, input string req);
        check(done === 1'b1, {req, " done pulse (R5)"}, {63'd0, done}, 64'd1);
        check(id_ok === ok, {req, " match flag (R4)"}, {63'd0, id_ok}, {63'd0, ok});
        check(crc_value === crc, {req, " crc value (R3)"}, {56'd0, crc_value}, {56'd0, crc});
        if (ok) last_uid = id;
        check(uid_out === last_uid, {req, " identifier (R6/R7)"}, uid_out, last_uid);
        idle(1);
        check(done === 1'b0, {req, " pulse width (R5)"}, {63'd0, done}, 64'd0);
    endtask

    initial begin
        logic [63:0] lf;
        logic [63:0] id;
        logic [7:0]  c;
        rst = 1'b1; in_start = 1'b0; in_valid = 1'b0; in_data = 8'h00;
        idle(3);
        // R1: reset state
        check(done === 1'b0 && id_ok === 1'b0, "R1 flags in reset", {62'd0, done, id_ok}, 64'd0);
        check(uid_out === 64'd0 && crc_value === 8'd0, "R1 data in reset", uid_out, 64'd0);
        @(negedge clk); rst = 1'b0;
        idle(1);
        check(done === 1'b0 && id_ok === 1'b0, "R1 flags after reset", {62'd0, done, id_ok}, 64'd0);

        // R9: bytes with no open record are ignored
        for (int i = 0; i < 12; i++) begin
            drive(1'b0, 8'(i * 17));
            check(done === 1'b0, "R9 no record, no done", {63'd0, done}, 64'd0);
        end
        idle(2);
        check(done === 1'b0 && uid_out === 64'd0, "R9 outputs untouched", uid_out, 64'd0);

        // R3 R4 R6: sweep every value of the first identifier byte
        for (int v = 0; v < 256; v++) begin
            id = {56'h0123456789ABCD, 8'(v)};
            c  = model_crc(id);
            send_rec(c, id, 0);
            expect_done(1'b1, id, c, "R3 sweep");
        end

        // R8: pseudo-random identifiers with idle gaps
        lf = 64'h9E3779B97F4A7C15;
        for (int n = 0; n < 32; n++) begin
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            lf = lf ^ (lf << 13) ^ 64'(n);
            c  = model_crc(lf);
            send_rec(c, lf, n % 3);
            expect_done(1'b1, lf, c, "R8 gaps");
        end

        // R7: every single-bit corruption of the stored checksum
        id = 64'hFEDCBA9876543210;
        c  = model_crc(id);
        for (int k = 0; k < 8; k++) begin
            send_rec(c ^ 8'(1 << k), id, 0);
            expect_done(1'b0, id, c, "R7 mismatch");
        end
        // all-zero identifier, correct checksum
        send_rec(model_crc(64'd0), 64'd0, 0);
        expect_done(1'b1, 64'd0, model_crc(64'd0), "R3 zero id");

        // R9: trailing bytes after a complete record are ignored
        for (int i = 0; i < 10; i++) begin
            drive(1'b0, 8'hC3);
            check(done === 1'b0, "R9 trailing byte", {63'd0, done}, 64'd0);
        end
        idle(2);
        check(uid_out === last_uid, "R9 identifier kept", uid_out, last_uid);

        // R10 R2: restart halfway through a record
        drive(1'b1, 8'h55);
        for (int i = 0; i < 4; i++) drive(1'b0, 8'(8'h10 + i));
        id = 64'h1122334455667788;
        c  = model_crc(id);
        drive(1'b1, c);
        for (int k = 0; k < 8; k++) begin
            drive(1'b0, id[8*k +: 8]);
            if (k < 7) check(done === 1'b0, "R10 no early done", {63'd0, done}, 64'd0);
        end
        idle(1);
        expect_done(1'b1, id, c, "R10 restart");

        idle(2);
        $display("%0d/%0d checks passed", npass, npass + nfail);
        $finish;
    end

endmodule